// File: doc/BRIEF.md
# Count-and-Condition Branch Resolver

This block resolves one branch per cycle. It merges two independent tests into a single taken/not-taken decision. The first test decrements a count register and tests the new value against zero. The second test reads one selectable bit of a 32-bit condition vector. Either test can be switched off on its own, and when both are off the branch is always taken. The block also forms the next fetch address. It picks among three target sources:

- a long immediate displacement, used by the unconditional form;
- a short immediate displacement, used by the conditional form;
- a target held in one of two architectural registers, the link register or the count register.

The count and link registers live inside the block. A branch with link update writes the return address into the link register. When the link register is also the target, the branch jumps to the link value held before that write. A load port lets a preceding register move place a value into either register. The next address, the taken flag and the illegal-combination flag are combinational outputs. Register updates appear on `ctr_o`/`lr_o` after the next rising clock edge.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `ctr_o` and `lr_o` are both zero.
- R2: With `cond_opt[0]`=0 and a conditional form (`tgt_sel` 1 or 2), a valid branch decrements the count register. The count test passes when the decremented value is zero if `cond_opt[1]`=1, and when it is nonzero if `cond_opt[1]`=0.
- R3: With `cond_opt[2]`=0 the bit test passes when `cr_bits[cr_sel]` (index 0 is the least significant bit) equals `cond_opt[3]`.
- R4: `cond_opt[0]`=1 makes the count test pass and leaves the count register unchanged. `cond_opt[2]`=1 makes the bit test pass. With both set, a conditional branch is always taken.
- R5: `tgt_sel`=0 is the unconditional long form. It is taken whatever `cond_opt` holds and never decrements. Its byte offset is the 24-bit `disp` shifted left by 2. In relative mode (`abs_mode`=0) the offset is sign-extended and added to `cia`. In absolute mode it is zero-extended, so only the low 64 MB can be reached.
- R6: `tgt_sel`=1 is the conditional short form. It uses only `disp[13:0]` shifted left by 2, with the same relative (sign-extended, added to `cia`) and absolute (zero-extended) rules.
- R7: `tgt_sel`=2 targets the link register and `tgt_sel`=3 targets the count register. In both cases the value is the one held before this branch, with its two low bits forced to zero.
- R8: A valid, legal branch with `link_en`=1 writes `cia`+4 into the link register whether it is taken or not.
- R9: When the branch is not taken, `next_addr` is `cia`+4.
- R10: `tgt_sel`=3 with `cond_opt[0]`=0 raises `illegal`. The branch is then not taken, and neither the count register nor the link register changes.
- R11: With `ld_en`=1, `ld_data` is written into the count register (`ld_sel`=0) or the link register (`ld_sel`=1). A load takes priority over a branch update of the same register in the same cycle.
- R12: With `br_valid`=0, `taken` is 0, `next_addr` is `cia`+4, and the branch changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is presented this cycle |
| cond_opt | input | 4 | [0] skip count test, [1] count sense (1 = zero), [2] skip bit test, [3] bit sense |
| cr_sel | input | 5 | Index of the tested condition bit |
| cr_bits | input | 32 | Condition bit vector |
| cia | input | 32 | Address of the current branch |
| disp | input | 24 | Displacement field, in words |
| abs_mode | input | 1 | Immediate target is absolute |
| link_en | input | 1 | Write the return address into the link register |
| tgt_sel | input | 2 | 0 long immediate, 1 short immediate, 2 link, 3 count |
| ld_en | input | 1 | Load a register from `ld_data` |
| ld_sel | input | 1 | 0 count register, 1 link register |
| ld_data | input | 32 | Load value |
| next_addr | output | 32 | Next fetch address |
| taken | output | 1 | Branch is taken |
| illegal | output | 1 | Count register used both as test and as target |
| ctr_o | output | 32 | Count register |
| lr_o | output | 32 | Link register |

## Verification
`next_addr`, `taken` and `illegal` depend only on the inputs and the current register contents, so they are due in the same cycle as the stimulus. The bench samples them two nanoseconds after it drives the inputs at the falling edge. Updates to the count and link registers become visible one rising edge later, and the bench reads `ctr_o` and `lr_o` one nanosecond after that edge. A behavioural model in the bench advances its own copies of both registers at each edge and is compared on every cycle, in both directed and random sequences.

// File: rtl/brr_pkg.sv
package brr_pkg;

  typedef enum logic [1:0] {
    TGT_LONG  = 2'd0,
    TGT_SHORT = 2'd1,
    TGT_LINK  = 2'd2,
    TGT_COUNT = 2'd3
  } tgt_sel_e;

  // bit order matches the cond_opt port: [3] bit_sense ... [0] cnt_skip
  typedef struct packed {
    logic bit_sense;
    logic bit_skip;
    logic cnt_zero;
    logic cnt_skip;
  } cond_opt_t;

endpackage

// File: rtl/brr_cond_eval.sv
module brr_cond_eval #(
  parameter int AW   = 32,
  parameter int CRW  = 32,
  localparam int SELW = $clog2(CRW)
) (
  input  brr_pkg::cond_opt_t opt_i,
  input  logic [CRW-1:0]     cr_i,
  input  logic [SELW-1:0]    sel_i,
  input  logic [AW-1:0]      ctr_i,
  output logic [AW-1:0]      ctr_dec_o,
  output logic               cnt_ok_o,
  output logic               bit_ok_o
);

  logic dec_is_zero;
  logic bit_val;

  always_comb begin
    ctr_dec_o   = ctr_i - AW'(1);
    dec_is_zero = (ctr_dec_o == '0);
    if (opt_i.cnt_skip) begin
      cnt_ok_o = 1'b1;
    end else begin
      cnt_ok_o = (dec_is_zero == opt_i.cnt_zero);
    end
  end

  always_comb begin
    bit_val = cr_i[sel_i];
    if (opt_i.bit_skip) begin
      bit_ok_o = 1'b1;
    end else begin
      bit_ok_o = (bit_val == opt_i.bit_sense);
    end
  end

endmodule

// File: rtl/brr_target_gen.sv
module brr_target_gen #(
  parameter int AW  = 32,
  parameter int LDW = 24,
  parameter int SDW = 14
) (
  input  brr_pkg::tgt_sel_e tsel_i,
  input  logic [LDW-1:0]    disp_i,
  input  logic              abs_i,
  input  logic [AW-1:0]     cia_i,
  input  logic [AW-1:0]     lr_i,
  input  logic [AW-1:0]     ctr_i,
  output logic [AW-1:0]     target_o,
  output logic [AW-1:0]     fall_o
);

  import brr_pkg::*;

  localparam int NFORM = 2;

  logic [NFORM-1:0][AW-1:0] rel_off;
  logic [NFORM-1:0][AW-1:0] abs_tgt;
  logic                     form_idx;
  logic [AW-1:0]            imm_tgt;
  logic [AW-1:0]            reg_src;

  // index 0: long unconditional field, index 1: short conditional field
  for (genvar f = 0; f < NFORM; f++) begin : g_form
    localparam int FW = (f == 0) ? LDW : SDW;
    logic [FW-1:0] fld;
    assign fld        = disp_i[FW-1:0];
    assign rel_off[f] = {{(AW-FW-2){fld[FW-1]}}, fld, 2'b00};
    assign abs_tgt[f] = {{(AW-FW-2){1'b0}}, fld, 2'b00};
  end

  always_comb begin
    form_idx = (tsel_i == TGT_SHORT);
    if (abs_i) begin
      imm_tgt = abs_tgt[form_idx];
    end else begin
      imm_tgt = cia_i + rel_off[form_idx];
    end
  end

  always_comb begin
    reg_src = (tsel_i == TGT_LINK) ? lr_i : ctr_i;
    unique case (tsel_i)
      TGT_LONG, TGT_SHORT: target_o = imm_tgt;
      default:             target_o = {reg_src[AW-1:2], 2'b00};
    endcase
    fall_o = cia_i + AW'(4);
  end

endmodule

// File: rtl/brr_spr_regs.sv
module brr_spr_regs #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctr_we_i,
  input  logic [AW-1:0] ctr_d_i,
  input  logic          lr_we_i,
  input  logic [AW-1:0] lr_d_i,
  output logic [AW-1:0] ctr_q_o,
  output logic [AW-1:0] lr_q_o
);

  localparam int NREG = 2;

  logic [1:0]               rst_sync_q;
  logic                     lrst_n;
  logic [NREG-1:0]          we;
  logic [NREG-1:0][AW-1:0]  d;
  logic [NREG-1:0][AW-1:0]  q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign lrst_n = rst_sync_q[1];

  assign we = {lr_we_i, ctr_we_i};
  assign d  = {lr_d_i, ctr_d_i};

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge lrst_n) begin
      if (!lrst_n) begin
        q[r] <= '0;
      end else if (we[r]) begin
        q[r] <= d[r];
      end
    end
  end

  assign ctr_q_o = q[0];
  assign lr_q_o  = q[1];

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int AW   = 32,
  parameter int CRW  = 32,
  parameter int LDW  = 24,
  parameter int SDW  = 14,
  localparam int SELW = $clog2(CRW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [3:0]      cond_opt,
  input  logic [SELW-1:0] cr_sel,
  input  logic [CRW-1:0]  cr_bits,
  input  logic [AW-1:0]   cia,
  input  logic [LDW-1:0]  disp,
  input  logic            abs_mode,
  input  logic            link_en,
  input  logic [1:0]      tgt_sel,
  input  logic            ld_en,
  input  logic            ld_sel,
  input  logic [AW-1:0]   ld_data,
  output logic [AW-1:0]   next_addr,
  output logic            taken,
  output logic            illegal,
  output logic [AW-1:0]   ctr_o,
  output logic [AW-1:0]   lr_o
);

  import brr_pkg::*;

  cond_opt_t   opt;
  tgt_sel_e    tsel;
  logic [AW-1:0] ctr_q, lr_q, ctr_dec, target, fall;
  logic        cnt_ok, bit_ok;
  logic        is_long, cnt_used, ill, br_ok;
  logic        ctr_we, lr_we;
  logic [AW-1:0] ctr_d, lr_d;

  assign opt  = cond_opt_t'(cond_opt);
  assign tsel = tgt_sel_e'(tgt_sel);

  brr_cond_eval #(.AW(AW), .CRW(CRW)) u_cond (
    .opt_i     (opt),
    .cr_i      (cr_bits),
    .sel_i     (cr_sel),
    .ctr_i     (ctr_q),
    .ctr_dec_o (ctr_dec),
    .cnt_ok_o  (cnt_ok),
    .bit_ok_o  (bit_ok)
  );

  brr_target_gen #(.AW(AW), .LDW(LDW), .SDW(SDW)) u_tgt (
    .tsel_i   (tsel),
    .disp_i   (disp),
    .abs_i    (abs_mode),
    .cia_i    (cia),
    .lr_i     (lr_q),
    .ctr_i    (ctr_q),
    .target_o (target),
    .fall_o   (fall)
  );

  // decision
  always_comb begin
    is_long  = (tsel == TGT_LONG);
    cnt_used = !is_long && !opt.cnt_skip;
    ill      = br_valid && (tsel == TGT_COUNT) && !opt.cnt_skip;
    br_ok    = br_valid && !ill;
    taken    = br_ok && (is_long || (cnt_ok && bit_ok));
    illegal  = ill;
    next_addr = taken ? target : fall;
  end

  // next-state for the special registers; a load wins over a branch update
  always_comb begin
    ctr_we = 1'b0;
    ctr_d  = ctr_dec;
    if (ld_en && !ld_sel) begin
      ctr_we = 1'b1;
      ctr_d  = ld_data;
    end else if (br_ok && cnt_used) begin
      ctr_we = 1'b1;
    end
  end

  always_comb begin
    lr_we = 1'b0;
    lr_d  = fall;
    if (ld_en && ld_sel) begin
      lr_we = 1'b1;
      lr_d  = ld_data;
    end else if (br_ok && link_en) begin
      lr_we = 1'b1;
    end
  end

  brr_spr_regs #(.AW(AW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctr_we_i (ctr_we),
    .ctr_d_i  (ctr_d),
    .lr_we_i  (lr_we),
    .lr_d_i   (lr_d),
    .ctr_q_o  (ctr_q),
    .lr_q_o   (lr_q)
  );

  assign ctr_o = ctr_q;
  assign lr_o  = lr_q;

endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
  parameter int AW   = 32,
  parameter int CRW  = 32,
  parameter int LDW  = 24,
  localparam int SELW = $clog2(CRW)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            br_valid,
  input logic [3:0]      cond_opt,
  input logic [SELW-1:0] cr_sel,
  input logic [CRW-1:0]  cr_bits,
  input logic [AW-1:0]   cia,
  input logic [LDW-1:0]  disp,
  input logic            abs_mode,
  input logic            link_en,
  input logic [1:0]      tgt_sel,
  input logic            ld_en,
  input logic            ld_sel,
  input logic [AW-1:0]   ld_data,
  input logic [AW-1:0]   next_addr,
  input logic            taken,
  input logic            illegal,
  input logic [AW-1:0]   ctr_o,
  input logic [AW-1:0]   lr_o
);

  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !taken); // R10

  AST_ILLEGAL_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !ld_en) |=> ($stable(ctr_o) && $stable(lr_o))); // R10

  AST_COUNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && (tgt_sel == 2'd1 || tgt_sel == 2'd2) && !cond_opt[0] && !(ld_en && !ld_sel))
    |=> (ctr_o == $past(ctr_o) - AW'(1))); // R2

  AST_LONG_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && tgt_sel == 2'd0) |-> taken); // R5

  AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && link_en && !illegal && !(ld_en && ld_sel))
    |=> (lr_o == $past(cia) + AW'(4))); // R8

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (next_addr == cia + AW'(4))); // R9

  AST_REG_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && tgt_sel[1]) |-> (next_addr[1:0] == 2'b00)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !ld_en) |=> ($stable(ctr_o) && $stable(lr_o))); // R12

  AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !taken); // R12

endmodule

bind branch_resolver brr_checker #(.AW(AW), .CRW(CRW), .LDW(LDW)) chk_i (.*);

// File: tb/branch_resolver_tb_top.sv
module branch_resolver_tb_top;

  logic        clk;
  logic        rst_n;
  logic        br_valid;
  logic [3:0]  cond_opt;
  logic [4:0]  cr_sel;
  logic [31:0] cr_bits;
  logic [31:0] cia;
  logic [23:0] disp;
  logic        abs_mode;
  logic        link_en;
  logic [1:0]  tgt_sel;
  logic        ld_en;
  logic        ld_sel;
  logic [31:0] ld_data;
  logic [31:0] next_addr;
  logic        taken;
  logic        illegal;
  logic [31:0] ctr_o;
  logic [31:0] lr_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_ctr, m_lr;

  branch_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .cond_opt(cond_opt),
    .cr_sel(cr_sel), .cr_bits(cr_bits), .cia(cia), .disp(disp),
    .abs_mode(abs_mode), .link_en(link_en), .tgt_sel(tgt_sel),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .next_addr(next_addr), .taken(taken), .illegal(illegal),
    .ctr_o(ctr_o), .lr_o(lr_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one branch cycle: drive at the falling edge, check combinational results,
  // then check the registers just after the next rising edge
  task automatic step(input logic v, input logic [3:0] opt, input logic [4:0] sel,
                      input logic [31:0] cr, input logic [31:0] a, input logic [23:0] d,
                      input logic ab, input logic lk, input logic [1:0] ts,
                      input logic le, input logic ls, input logic [31:0] ldv,
                      input string tag);
    logic        is_long, cnt_used, ill, cok, bok, tk;
    logic [31:0] newc, off, tgt, exp_next, fall;
    @(negedge clk);
    br_valid = v; cond_opt = opt; cr_sel = sel; cr_bits = cr; cia = a; disp = d;
    abs_mode = ab; link_en = lk; tgt_sel = ts; ld_en = le; ld_sel = ls; ld_data = ldv;
    is_long  = (ts == 2'd0);
    cnt_used = !is_long && !opt[0];
    ill      = v && (ts == 2'd3) && !opt[0];
    newc     = m_ctr - 32'd1;
    cok      = opt[0] || ((newc == 32'd0) == opt[1]);
    bok      = opt[2] || (cr[sel] == opt[3]);
    tk       = v && !ill && (is_long || (cok && bok));
    fall     = a + 32'd4;
    if (ts == 2'd0) off = {{6{d[23]}}, d, 2'b00};
    else            off = {{16{d[13]}}, d[13:0], 2'b00};
    case (ts)
      2'd0:    tgt = ab ? {6'd0, d, 2'b00} : a + off;
      2'd1:    tgt = ab ? {16'd0, d[13:0], 2'b00} : a + off;
      2'd2:    tgt = m_lr & 32'hFFFF_FFFC;
      default: tgt = m_ctr & 32'hFFFF_FFFC;
    endcase
    exp_next = tk ? tgt : fall;
    #2;
    check32(tag, "taken", {31'd0, taken}, {31'd0, tk});
    check32(tag, "illegal", {31'd0, illegal}, {31'd0, ill});
    check32(tag, "next_addr", next_addr, exp_next);
    if (le && !ls)                   m_ctr = ldv;
    else if (v && cnt_used && !ill)  m_ctr = newc;
    if (le && ls)                    m_lr = ldv;
    else if (v && lk && !ill)        m_lr = fall;
    @(posedge clk);
    #1;
    check32(tag, "ctr", ctr_o, m_ctr);
    check32(tag, "lr", lr_o, m_lr);
  endtask

  task automatic load(input logic which, input logic [31:0] val, input string tag);
    step(1'b0, 4'h0, 5'd0, 32'h0, 32'h100, 24'h0, 1'b0, 1'b0, 2'd0, 1'b1, which, val, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; br_valid = 1'b0; cond_opt = '0; cr_sel = '0; cr_bits = '0;
    cia = '0; disp = '0; abs_mode = 1'b0; link_en = 1'b0; tgt_sel = '0;
    ld_en = 1'b0; ld_sel = 1'b0; ld_data = '0;
    m_ctr = '0; m_lr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check32("R1", "ctr after reset", ctr_o, 32'd0);
    check32("R1", "lr after reset", lr_o, 32'd0);

    // R11 load count, then R2 loop on nonzero: taken, taken, not taken
    load(1'b0, 32'd3, "R11");
    for (int i = 0; i < 3; i++)
      step(1'b1, 4'b0100, 5'd0, 32'h0, 32'h400, 24'h000010, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R2");
    // R2 branch on zero
    load(1'b0, 32'd1, "R11");
    step(1'b1, 4'b0110, 5'd0, 32'h0, 32'h800, 24'h000008, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R2");
    step(1'b1, 4'b0110, 5'd0, 32'h0, 32'h800, 24'h000008, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R2");

    // R3 bit test (count skipped, R4 count unchanged)
    load(1'b0, 32'd7, "R11");
    step(1'b1, 4'b1001, 5'd15, 32'h0000_8000, 32'h1000, 24'h000004, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R3");
    step(1'b1, 4'b0001, 5'd15, 32'h0000_8000, 32'h1000, 24'h000004, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R3");
    step(1'b1, 4'b1001, 5'd14, 32'h0000_8000, 32'h1000, 24'h000004, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R3");
    step(1'b1, 4'b1001, 5'd31, 32'h8000_0000, 32'h1000, 24'h000004, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R3");
    // R4 both skipped
    step(1'b1, 4'b0101, 5'd3, 32'h0, 32'h2000, 24'h000020, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R4");

    // R5 long form: taken despite failing options, no decrement
    step(1'b1, 4'b1000, 5'd0, 32'h0, 32'h1000, 24'hFFFFFF, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b1, 4'b0000, 5'd0, 32'h0, 32'h1000, 24'hFFFFFF, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, "R5");
    step(1'b1, 4'b0000, 5'd0, 32'h0, 32'h1000, 24'h7FFFFF, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, "R5");

    // R6 short form: upper displacement bits ignored
    step(1'b1, 4'b0101, 5'd0, 32'h0, 32'h1000, 24'hFF2000, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R6");
    step(1'b1, 4'b0101, 5'd0, 32'h0, 32'h1000, 24'hAB3FFF, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 32'h0, "R6");

    // R7 and R8 link target with link update uses the old link value
    load(1'b1, 32'h1234_5677, "R11");
    step(1'b1, 4'b0101, 5'd0, 32'h0, 32'h3000, 24'h0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0, "R8");
    load(1'b0, 32'h0000_2003, "R11");
    step(1'b1, 4'b0101, 5'd0, 32'h0, 32'h3100, 24'h0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 32'h0, "R7");

    // R10 illegal: count as both test and target
    step(1'b1, 4'b0100, 5'd0, 32'h0, 32'h3200, 24'h0, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 32'h0, "R10");

    // R9 not taken with link update still writes link
    step(1'b1, 4'b0001, 5'd2, 32'h0000_0004, 32'h4000, 24'h000040, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 32'h0, "R9");

    // R11 load wins over same-cycle decrement and link write
    step(1'b1, 4'b0100, 5'd0, 32'h0, 32'h5000, 24'h4, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 32'd9, "R11");
    step(1'b1, 4'b0101, 5'd0, 32'h0, 32'h5000, 24'h4, 1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 32'hCAFE_0000, "R11");

    // R12 idle branch fields have no effect
    step(1'b0, 4'b0100, 5'd0, 32'h0, 32'h6000, 24'h4, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 32'h0, "R12");

    // random mix
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 7) != 0, 4'($urandom), 5'($urandom), $urandom,
           {$urandom_range(0, 32'h3FFF_FFFF), 2'b00}, 24'($urandom), 1'($urandom),
           1'($urandom), 2'($urandom), $urandom_range(0, 5) == 0, 1'($urandom),
           (n % 9 == 0) ? 32'd1 : 32'($urandom_range(0, 6)), "R2/R3/R7");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule